// File: doc/BRIEF.md
# Shift and Sign-Extend Unit

This block is the shift datapath of a 32-bit integer core. It takes one operand, a shift amount and a three-bit operation code, and produces a result word. It offers three multi-bit barrel shifts, three single-position right shifts that interact with the core's carry flag, and sign extension of a byte or a halfword.

The single-position shifts always move the operand's bit 0 out into the carry flag. They assert a carry write-enable so that the surrounding core updates its flag. The three forms differ only in what enters the vacated top bit: a copy of the sign, a zero, or the previous carry. The barrel shifts and the sign extensions leave the flag alone.

The shift amount may come from a register or from an instruction immediate. In both cases only its low five bits are used, so an amount of 32 or more wraps. The logic is purely combinational. An output register, selected by a parameter and enabled by default, adds one cycle of latency.

Top module: `shx_unit`

## Requirements
- R1: Operation code 0 is a barrel logical right shift. The result is operand A shifted right by the effective amount, and zeros enter at the top.
- R2: Operation code 1 is a barrel arithmetic right shift. Copies of A's bit 31 enter at the top.
- R3: Operation code 2 is a barrel logical left shift. Zeros enter at bit 0.
- R4: The effective barrel amount is the low five bits of the amount input. Amount 32 behaves as 0, and amount 37 behaves as 5.
- R5: For operation codes 0, 1, 2, 6 and 7, the carry write-enable is 0 and the carry output equals the carry input.
- R6: Operation code 3 is a one-bit arithmetic right shift. The result is {A[31], A[31:1]}, the carry output is A[0], and the carry write-enable is 1.
- R7: Operation code 4 is a one-bit logical right shift. The result is {0, A[31:1]}, the carry output is A[0], and the write-enable is 1.
- R8: Operation code 5 is a one-bit right shift through carry. The result is {carry_i, A[31:1]}, the carry output is A[0], and the write-enable is 1.
- R9: Operation code 6 is a byte sign extension. Bits 31..8 of the result copy A[7], and bits 7..0 equal A[7:0].
- R10: Operation code 7 is a halfword sign extension. Bits 31..16 of the result copy A[15], and bits 15..0 equal A[15:0].
- R11: With the output register enabled, the outputs appear one clock after the inputs. While reset is low, the result, the carry output and the write-enable are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Operation code |
| opa_i | input | 32 | Operand A |
| amt_i | input | 32 | Shift amount, from a register or an immediate |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Result word |
| carry_o | output | 1 | New carry value |
| carry_we_o | output | 1 | Carry write-enable |

## Verification
The assertions assume that the operation code, the operand, the amount and the carry input are stable and known at each rising clock edge. They judge every output against the inputs that were present at the previous edge.

The stimulus drives all inputs on the falling edge. Every operation code it uses is one of the eight defined codes. It samples the outputs on the following falling edge, once the single register stage has loaded.

// File: rtl/shx_pkg.sv
package shx_pkg;

    localparam int BYTE_W = 8;
    localparam int HALF_W = 16;

    typedef enum logic [2:0] {
        OP_BSRL  = 3'd0,
        OP_BSRA  = 3'd1,
        OP_BSLL  = 3'd2,
        OP_SRA1  = 3'd3,
        OP_SRL1  = 3'd4,
        OP_SRC1  = 3'd5,
        OP_SEXT8 = 3'd6,
        OP_SEXT16 = 3'd7
    } shx_op_e;

endpackage

// File: rtl/shx_barrel.sv
module shx_barrel #(
    parameter int WIDTH = 32,
    parameter int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [AMT_W-1:0] amt_i,
    input  logic             left_i,
    input  logic             arith_i,
    output logic [WIDTH-1:0] data_o
);
    logic             fill;
    logic [WIDTH-1:0] rev_in;
    logic [WIDTH-1:0] rev_out;
    logic [WIDTH-1:0] stage [AMT_W+1];

    // left shift = reverse, shift right with zero fill, reverse back
    assign fill = arith_i & ~left_i & data_i[WIDTH-1];

    for (genvar b = 0; b < WIDTH; b++) begin : g_rev
        assign rev_in[b]  = data_i[WIDTH-1-b];
        assign rev_out[b] = stage[AMT_W][WIDTH-1-b];
    end

    assign stage[0] = left_i ? rev_in : data_i;

    for (genvar s = 0; s < AMT_W; s++) begin : g_stage
        localparam int SH = 1 << s;
        assign stage[s+1] = amt_i[s] ? {{SH{fill}}, stage[s][WIDTH-1:SH]}
                                     : stage[s];
    end

    assign data_o = left_i ? rev_out : stage[AMT_W];

endmodule

// File: rtl/shx_single.sv
module shx_single import shx_pkg::*; #(
    parameter int WIDTH = 32
) (
    input  shx_op_e          op_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] data_o,
    output logic             carry_o
);
    logic top_bit;

    always_comb begin
        unique case (op_i)
            OP_SRA1: top_bit = data_i[WIDTH-1];
            OP_SRC1: top_bit = carry_i;
            default: top_bit = 1'b0;
        endcase
    end

    assign data_o  = {top_bit, data_i[WIDTH-1:1]};
    assign carry_o = data_i[0];

endmodule

// File: rtl/shx_sext.sv
module shx_sext #(
    parameter int WIDTH  = 32,
    parameter int FROM_W = 8
) (
    input  logic [WIDTH-1:0] data_i,
    output logic [WIDTH-1:0] data_o
);
    localparam int EXT_W = WIDTH - FROM_W;

    assign data_o = {{EXT_W{data_i[FROM_W-1]}}, data_i[FROM_W-1:0]};

endmodule

// File: rtl/shx_unit.sv
module shx_unit import shx_pkg::*; #(
    parameter int WIDTH   = 32,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [2:0]       op_i,
    input  logic [WIDTH-1:0] opa_i,
    input  logic [WIDTH-1:0] amt_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o,
    output logic             carry_we_o
);
    localparam int AMT_W = $clog2(WIDTH);

    shx_op_e          op;
    logic [AMT_W-1:0] amt_eff;
    logic             unused_amt_hi;
    logic [WIDTH-1:0] barrel_res;
    logic [WIDTH-1:0] single_res;
    logic             single_carry;
    logic [WIDTH-1:0] byte_res;
    logic [WIDTH-1:0] half_res;
    logic [WIDTH-1:0] nxt_result;
    logic             nxt_carry;
    logic             nxt_we;

    assign op            = shx_op_e'(op_i);
    assign amt_eff       = amt_i[AMT_W-1:0];
    assign unused_amt_hi = ^amt_i[WIDTH-1:AMT_W];

    shx_barrel #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_barrel (
        .data_i  (opa_i),
        .amt_i   (amt_eff),
        .left_i  (op == OP_BSLL),
        .arith_i (op == OP_BSRA),
        .data_o  (barrel_res)
    );

    shx_single #(.WIDTH(WIDTH)) u_single (
        .op_i    (op),
        .data_i  (opa_i),
        .carry_i (carry_i),
        .data_o  (single_res),
        .carry_o (single_carry)
    );

    shx_sext #(.WIDTH(WIDTH), .FROM_W(BYTE_W)) u_sext_byte (
        .data_i (opa_i),
        .data_o (byte_res)
    );

    shx_sext #(.WIDTH(WIDTH), .FROM_W(HALF_W)) u_sext_half (
        .data_i (opa_i),
        .data_o (half_res)
    );

    always_comb begin
        nxt_carry = carry_i;
        nxt_we    = 1'b0;
        unique case (op)
            OP_BSRL, OP_BSRA, OP_BSLL: nxt_result = barrel_res;
            OP_SRA1, OP_SRL1, OP_SRC1: begin
                nxt_result = single_res;
                nxt_carry  = single_carry;
                nxt_we     = 1'b1;
            end
            OP_SEXT8:  nxt_result = byte_res;
            OP_SEXT16: nxt_result = half_res;
            default:   nxt_result = '0;
        endcase
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                result_o   <= '0;
                carry_o    <= 1'b0;
                carry_we_o <= 1'b0;
            end else begin
                result_o   <= nxt_result;
                carry_o    <= nxt_carry;
                carry_we_o <= nxt_we;
            end
        end
    end else begin : g_comb
        logic unused_clk;
        assign unused_clk = clk ^ rst_n;
        assign result_o   = nxt_result;
        assign carry_o    = nxt_carry;
        assign carry_we_o = nxt_we;
    end

endmodule

// File: rtl/shx_unit_chk.sv
module shx_unit_chk import shx_pkg::*; #(
    parameter int WIDTH   = 32,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       op_i,
    input logic [WIDTH-1:0] opa_i,
    input logic [WIDTH-1:0] amt_i,
    input logic             carry_i,
    input logic [WIDTH-1:0] result_o,
    input logic             carry_o,
    input logic             carry_we_o
);
    localparam int AMT_W = $clog2(WIDTH);

    // inputs that produced the outputs now visible
    logic [2:0]       v_op;
    logic [WIDTH-1:0] v_a;
    logic [WIDTH-1:0] v_amt;
    logic             v_c;
    logic             v_single;
    logic             v_barrel;
    logic             unused_amt;

    if (REG_OUT) begin : g_d
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                v_op  <= '0;
                v_a   <= '0;
                v_amt <= '0;
                v_c   <= 1'b0;
            end else begin
                v_op  <= op_i;
                v_a   <= opa_i;
                v_amt <= amt_i;
                v_c   <= carry_i;
            end
        end

        assert_reset_clear_R11: assert property (@(posedge clk)
            !rst_n |=> (result_o == '0 && !carry_o && !carry_we_o));
    end else begin : g_nd
        assign v_op  = op_i;
        assign v_a   = opa_i;
        assign v_amt = amt_i;
        assign v_c   = carry_i;
    end

    assign v_single   = (v_op == OP_SRA1) || (v_op == OP_SRL1) || (v_op == OP_SRC1);
    assign v_barrel   = (v_op == OP_BSRL) || (v_op == OP_BSRA) || (v_op == OP_BSLL);
    assign unused_amt = ^v_amt[WIDTH-1:AMT_W];

    assert_no_carry_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !v_single |-> (!carry_we_o && carry_o == v_c));

    assert_carry_from_bit0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        v_single |-> (carry_we_o && carry_o == v_a[0]
                      && result_o[WIDTH-2:0] == v_a[WIDTH-1:1]));

    assert_srl_top_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (v_op == OP_SRL1) |-> !result_o[WIDTH-1]);

    assert_src_top_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (v_op == OP_SRC1) |-> (result_o[WIDTH-1] == v_c));

    assert_sext_byte_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (v_op == OP_SEXT8) |-> (result_o == {{(WIDTH-BYTE_W){v_a[BYTE_W-1]}},
                                             v_a[BYTE_W-1:0]}));

    assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (v_barrel && v_amt[AMT_W-1:0] == '0) |-> (result_o == v_a));

endmodule

bind shx_unit shx_unit_chk #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/shx_unit_test.sv
module shx_unit_test;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   op_i = 3'd0;
    logic [W-1:0] opa_i = '0;
    logic [W-1:0] amt_i = '0;
    logic         carry_i = 1'b0;
    logic [W-1:0] result_o;
    logic         carry_o;
    logic         carry_we_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    shx_unit #(.WIDTH(W), .REG_OUT(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .op_i(op_i), .opa_i(opa_i), .amt_i(amt_i),
        .carry_i(carry_i), .result_o(result_o), .carry_o(carry_o),
        .carry_we_o(carry_we_o)
    );

    task automatic chk(input string req, input logic [W-1:0] got,
                       input logic [W-1:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // drive on a falling edge, sample on the next falling edge
    task automatic apply(input logic [2:0] op, input logic [W-1:0] a,
                         input logic [W-1:0] amt, input logic c);
        @(negedge clk);
        op_i = op; opa_i = a; amt_i = amt; carry_i = c;
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        apply(3'd3, 32'hFFFF_FFFF, 32'd1, 1'b1);
        chk("R11 reset result", result_o, '0);
        chk("R11 reset carry", {31'd0, carry_o}, '0);
        chk("R11 reset we", {31'd0, carry_we_o}, '0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_barrel(input logic [2:0] op, input string req,
                            input logic [W-1:0] a);
        int amts [5] = '{0, 1, 31, 32, 37};
        foreach (amts[k]) begin
            int n = amts[k] % 32;
            logic [W-1:0] exp;
            case (op)
                3'd0:    exp = a >> n;
                3'd1:    exp = $unsigned($signed(a) >>> n);
                default: exp = a << n;
            endcase
            apply(op, a, amts[k], 1'b1);
            chk((amts[k] >= 32) ? {req, " R4 wrap"} : req, result_o, exp);
            chk("R5 barrel no carry write", {30'd0, carry_we_o, carry_o}, 32'd1);
        end
    endtask

    task automatic t_single(input logic [2:0] op, input string req,
                            input logic [W-1:0] a, input logic c);
        logic top;
        case (op)
            3'd3:    top = a[31];
            3'd5:    top = c;
            default: top = 1'b0;
        endcase
        apply(op, a, 32'd9, c);
        chk(req, result_o, {top, a[31:1]});
        chk({req, " carry"}, {30'd0, carry_we_o, carry_o}, {30'd0, 1'b1, a[0]});
    endtask

    task automatic t_sext(input logic [W-1:0] a, input logic c);
        apply(3'd6, a, 32'd0, c);
        chk("R9 sext byte", result_o, {{24{a[7]}}, a[7:0]});
        chk("R5 sext byte no write", {30'd0, carry_we_o, carry_o}, {31'd0, c});
        apply(3'd7, a, 32'd0, c);
        chk("R10 sext half", result_o, {{16{a[15]}}, a[15:0]});
        chk("R5 sext half no write", {30'd0, carry_we_o, carry_o}, {31'd0, c});
    endtask

    initial begin
        t_reset();
        t_barrel(3'd0, "R1 bsrl", 32'h8000_00F1);
        t_barrel(3'd0, "R1 bsrl", 32'h1234_5678);
        t_barrel(3'd1, "R2 bsra neg", 32'h8000_00F1);
        t_barrel(3'd1, "R2 bsra pos", 32'h7000_0003);
        t_barrel(3'd2, "R3 bsll", 32'h8000_00F1);
        t_barrel(3'd2, "R3 bsll", 32'hC001_0001);
        t_single(3'd3, "R6 sra1", 32'h8000_0003, 1'b0);
        t_single(3'd3, "R6 sra1", 32'h4000_0002, 1'b1);
        t_single(3'd4, "R7 srl1", 32'hFFFF_FFFF, 1'b1);
        t_single(3'd4, "R7 srl1", 32'h0000_0002, 1'b0);
        t_single(3'd5, "R8 src1", 32'h0000_0001, 1'b1);
        t_single(3'd5, "R8 src1", 32'hFFFF_FFFE, 1'b0);
        t_sext(32'h1234_5680, 1'b1);
        t_sext(32'hFFFF_7F7F, 1'b0);
        t_reset();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog got=timeout exp=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule